// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the clock set for a serial audio port from one fast source clock (nominally 32 MHz). An integer divisor, picked from an irregular table that includes odd and prime values, turns the source into the master clock. A ratio code then sets the word-select period as a multiple of master-clock periods. The bit clock is spread evenly so that each word-select half-period holds exactly the programmed number of bit-clock periods. A one-cycle strobe marks the start of every frame.

Operation is controlled by two pulses. A start pulse captures the whole configuration, zeroes every counter and begins continuous output. A stop pulse forces all outputs low. The master clock can be switched off while the word and bit clocks still run. A bypass setting instead passes the source clock straight through as the master clock. All logic runs in the source clock domain.

Top module: `audclk_gen`

## Requirements
- R1: `div_code` values 0 to 17 select source divisors 2, 3, 4, 5, 6, 8, 10, 11, 15, 16, 21, 23, 30, 31, 32, 42, 63 and 125, in that code order.
- R2: With divisor N, counting source cycles k from 0 in the first cycle after a start, `mck` is high when (k mod N) < floor(N/2) and low otherwise. The high time is therefore floor(N/2) cycles and the low time ceil(N/2).
- R3: `ratio_code` values 0 to 8 select ratios 32, 48, 64, 96, 128, 192, 256, 384 and 512. `lrck` equals ((k div H) mod 2), where H = N*R/2 source cycles, so the first half after a start is low and has full length.
- R4: `sck` equals ((k*2W div H) mod 2), with W = `half_bits`. Each `lrck` half-period then holds exactly W `sck` periods. This holds when 2W <= H.
- R5: `frame_start` is high for exactly the cycles where k is a multiple of 2H, that is the first cycle of every low `lrck` half, including the first cycle after a start.
- R6: If `mck_en` is low at start, `mck` stays low for the whole run while `lrck`, `sck` and `frame_start` run as normal.
- R7: If `bypass` is set at start, `mck` follows the source clock level, `div_code` has no effect, and N = 1 is used for H.
- R8: In the cycle after a stop pulse, and until the next start, `mck`, `sck`, `lrck` and `frame_start` are all low.
- R9: A start and a stop in the same cycle act as a stop.
- R10: Configuration inputs are captured only on a start. Changing them during a run has no effect on the outputs. A start during a run realigns the outputs to k = 0.
- R11: While `rst` is high and after its release, all outputs are low until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Capture configuration and begin output |
| stop_pulse | input | 1 | Halt all outputs |
| mck_en | input | 1 | Master clock output enable, captured at start |
| div_code | input | 5 | Divisor select code |
| ratio_code | input | 4 | Master-to-word clock ratio select |
| bypass | input | 1 | Pass the source clock through as master clock |
| half_bits | input | WID_W | Bit-clock periods per word-select half |
| mck | output | 1 | Master clock |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Word-select clock |
| frame_start | output | 1 | One-cycle strobe at each frame start |

## Verification
A stop pulse can land in the same cycle as a start. It can also land on the cycle where `lrck` would fall and raise `frame_start`. The bench drives both pulses together, once during a run and once from the stopped state, and requires all outputs to stay low for the following cycles. It also stops a run on a frame boundary and checks that no strobe escapes. A second start during a run must restart the frame at once, with the strobe high and both clocks low in the next cycle.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  localparam int DIV_W = 7;   // widest divisor value is 125
  localparam int RAT_W = 10;  // widest ratio value is 512

  // Divisor select; codes past the table fall back to the slowest divisor.
  function automatic logic [DIV_W-1:0] div_lookup(input logic [4:0] code);
    case (code)
      5'd0:    return 7'd2;
      5'd1:    return 7'd3;
      5'd2:    return 7'd4;
      5'd3:    return 7'd5;
      5'd4:    return 7'd6;
      5'd5:    return 7'd8;
      5'd6:    return 7'd10;
      5'd7:    return 7'd11;
      5'd8:    return 7'd15;
      5'd9:    return 7'd16;
      5'd10:   return 7'd21;
      5'd11:   return 7'd23;
      5'd12:   return 7'd30;
      5'd13:   return 7'd31;
      5'd14:   return 7'd32;
      5'd15:   return 7'd42;
      5'd16:   return 7'd63;
      default: return 7'd125;
    endcase
  endfunction

  // Ratio select; codes past the table fall back to the largest ratio.
  function automatic logic [RAT_W-1:0] ratio_lookup(input logic [3:0] code);
    case (code)
      4'd0:    return 10'd32;
      4'd1:    return 10'd48;
      4'd2:    return 10'd64;
      4'd3:    return 10'd96;
      4'd4:    return 10'd128;
      4'd5:    return 10'd192;
      4'd6:    return 10'd256;
      4'd7:    return 10'd384;
      default: return 10'd512;
    endcase
  endfunction

endpackage

// File: rtl/audclk_mck_div.sv
module audclk_mck_div #(
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic          adv,
  input  logic [DW-1:0] div,
  output logic          mck_raw
);

  logic [DW-1:0] cnt;
  logic [DW-1:0] nxt;

  always_comb nxt = (cnt == div - 1'b1) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      mck_raw <= 1'b0;
    end else if (load) begin
      cnt     <= '0;
      mck_raw <= 1'b1;          // every divisor is at least 2
    end else if (adv) begin
      cnt     <= nxt;
      mck_raw <= (nxt < (div >> 1));
    end
  end

endmodule

// File: rtl/audclk_frame_gen.sv
module audclk_frame_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] half_len,
  output logic             lrck,
  output logic             frame_start
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt         <= '0;
      lrck        <= 1'b0;
      frame_start <= 1'b0;
    end else if (load) begin
      cnt         <= '0;
      lrck        <= 1'b0;
      frame_start <= 1'b1;
    end else if (adv) begin
      if (cnt == half_len - 1'b1) begin
        cnt         <= '0;
        lrck        <= ~lrck;
        frame_start <= lrck;    // high-to-low turn opens a new frame
      end else begin
        cnt         <= cnt + 1'b1;
        frame_start <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audclk_bit_gen.sv
module audclk_bit_gen #(
  parameter int CNT_W = 16,
  parameter int WID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] half_len,
  input  logic [WID_W:0]   step,      // twice the bits per half-frame
  output logic             sck
);

  logic [CNT_W-1:0] acc;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   lim;

  always_comb begin
    sum = {1'b0, acc} + (CNT_W + 1)'(step);
    lim = {1'b0, half_len};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      sck <= 1'b0;
    end else if (load) begin
      acc <= '0;
      sck <= 1'b0;
    end else if (adv) begin
      if (sum >= lim) begin
        acc <= CNT_W'(sum - lim);
        sck <= ~sck;
      end else begin
        acc <= CNT_W'(sum);
      end
    end
  end

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pulse,
  input  logic             stop_pulse,
  input  logic             mck_en,
  input  logic [4:0]       div_code,
  input  logic [3:0]       ratio_code,
  input  logic             bypass,
  input  logic [WID_W-1:0] half_bits,
  output logic             mck,
  output logic             sck,
  output logic             lrck,
  output logic             frame_start
);

  localparam int PROD_W = CNT_W + 1;

  logic             go;
  logic             halt;
  logic [DIV_W-1:0] div_in;
  logic [RAT_W-1:0] rat_in;
  logic [PROD_W-1:0] prod_in;

  logic             run_q;
  logic             en_q;
  logic             byp_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] half_q;
  logic [WID_W:0]   step_q;
  logic             mck_div;

  assign halt = stop_pulse;
  assign go   = start_pulse & ~stop_pulse;   // stop has priority

  always_comb begin
    div_in  = bypass ? DIV_W'(1) : div_lookup(div_code);
    rat_in  = ratio_lookup(ratio_code);
    prod_in = PROD_W'(div_in) * PROD_W'(rat_in);
  end

  // Configuration is held from one start to the next.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      div_q  <= DIV_W'(2);
      half_q <= CNT_W'(1);
      step_q <= '0;
    end else if (halt) begin
      run_q  <= 1'b0;
    end else if (go) begin
      run_q  <= 1'b1;
      en_q   <= mck_en;
      byp_q  <= bypass;
      div_q  <= div_in;
      half_q <= CNT_W'(prod_in >> 1);
      step_q <= {half_bits, 1'b0};
    end
  end

  audclk_mck_div #(.DW(DIV_W)) u_mck (
    .clk     (clk),
    .rst     (rst),
    .clr     (halt),
    .load    (go),
    .adv     (run_q),
    .div     (div_q),
    .mck_raw (mck_div)
  );

  audclk_frame_gen #(.CNT_W(CNT_W)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .clr         (halt),
    .load        (go),
    .adv         (run_q),
    .half_len    (half_q),
    .lrck        (lrck),
    .frame_start (frame_start)
  );

  audclk_bit_gen #(.CNT_W(CNT_W), .WID_W(WID_W)) u_bit (
    .clk      (clk),
    .rst      (rst),
    .clr      (halt),
    .load     (go),
    .adv      (run_q),
    .half_len (half_q),
    .step     (step_q),
    .sck      (sck)
  );

  // Bypass passes the source clock through; the gate opens only while running.
  assign mck = run_q & en_q & (byp_q ? clk : mck_div);

endmodule

// File: rtl/audclk_gen_sva.sv
module audclk_gen_sva (
  input logic clk,
  input logic rst,
  input logic start_pulse,
  input logic stop_pulse,
  input logic sck,
  input logic lrck,
  input logic frame_start
);

  // R5
  fs_left_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !lrck);

  // R5
  lrck_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(lrck) && !$past(stop_pulse)) |-> frame_start);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stop_pulse) |-> (!lrck && !sck && !frame_start));

  // R10
  start_align_chk: assert property (@(posedge clk) disable iff (rst)
    $past(start_pulse && !stop_pulse) |-> (frame_start && !lrck && !sck));

  // R9
  clash_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(start_pulse && stop_pulse) |-> !frame_start);

endmodule

bind audclk_gen audclk_gen_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .sck         (sck),
  .lrck        (lrck),
  .frame_start (frame_start)
);

// File: tb/audclk_gen_test.sv
`timescale 1ns/1ps
module audclk_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_pulse = 1'b0;
  logic       stop_pulse = 1'b0;
  logic       mck_en = 1'b0;
  logic [4:0] div_code = 5'd0;
  logic [3:0] ratio_code = 4'd0;
  logic       bypass = 1'b0;
  logic [5:0] half_bits = 6'd0;
  logic       mck, sck, lrck, frame_start;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audclk_gen uut (
    .clk (clk), .rst (rst), .start_pulse (start_pulse), .stop_pulse (stop_pulse),
    .mck_en (mck_en), .div_code (div_code), .ratio_code (ratio_code),
    .bypass (bypass), .half_bits (half_bits),
    .mck (mck), .sck (sck), .lrck (lrck), .frame_start (frame_start)
  );

  // {div_code, ratio_code, half_bits, mck_en, bypass, expected N, expected R}
  localparam logic [33:0] VEC [8] = '{
    {5'd1,  4'd0, 6'd16, 1'b1, 1'b0, 7'd3,   10'd32},
    {5'd7,  4'd1, 6'd24, 1'b1, 1'b0, 7'd11,  10'd48},
    {5'd17, 4'd0, 6'd8,  1'b1, 1'b0, 7'd125, 10'd32},
    {5'd0,  4'd8, 6'd32, 1'b1, 1'b0, 7'd2,   10'd512},
    {5'd13, 4'd2, 6'd16, 1'b0, 1'b0, 7'd31,  10'd64},
    {5'd4,  4'd3, 6'd24, 1'b1, 1'b0, 7'd6,   10'd96},
    {5'd11, 4'd4, 6'd16, 1'b1, 1'b0, 7'd23,  10'd128},
    {5'd16, 4'd0, 6'd8,  1'b1, 1'b1, 7'd1,   10'd32}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at posedge+1; leaves at posedge+1 of the next cycle.
  task automatic do_start();
    @(negedge clk) start_pulse = 1'b1;
    @(posedge clk); #1 start_pulse = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_pulse = 1'b1;
    @(posedge clk); #1 stop_pulse = 1'b0;
  endtask

  task automatic check_idle(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check({tag, " mck"}, mck, 0);
      check({tag, " lrck"}, lrck, 0);
      check({tag, " sck"}, sck, 0);
      check({tag, " frame_start"}, frame_start, 0);
    end
    @(posedge clk); #1;
  endtask

  // Checks cycles k0..k1-1 of a run against the requirement formulas.
  task automatic check_cycles(input int n, input int h, input int w, input bit en,
                              input bit byp, input int k0, input int k1, input string mtag);
    for (int k = k0; k < k1; k++) begin
      if (byp) check("R7 mck high phase", mck, en);
      @(negedge clk);
      if (byp) check("R7 mck low phase", mck, 0);
      else     check(mtag, mck, en ? (((k % n) < (n / 2)) ? 1 : 0) : 0);
      check("R3 lrck", lrck, (k / h) % 2);
      check("R4 sck", sck, ((k * 2 * w) / h) % 2);
      check("R5 frame_start", frame_start, ((k % (2 * h)) == 0) ? 1 : 0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 mck", mck, 0);
    check("R11 lrck", lrck, 0);
    check("R11 sck", sck, 0);
    check("R11 frame_start", frame_start, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check_idle(4, "R11");

    // Table walk: R1, R2, R3, R4, R5, R6, R7
    for (int v = 0; v < 8; v++) begin
      int n, r, h, w;
      div_code   = VEC[v][33:29];
      ratio_code = VEC[v][28:25];
      half_bits  = VEC[v][24:19];
      mck_en     = VEC[v][18];
      bypass     = VEC[v][17];
      n = int'(VEC[v][16:10]);
      r = int'(VEC[v][9:0]);
      h = n * r / 2;
      w = int'(VEC[v][24:19]);
      do_start();
      check_cycles(n, h, w, VEC[v][18], VEC[v][17], 0, 4 * h + 3,
                   VEC[v][18] ? "R1 R2 mck" : "R6 mck");
      do_stop();
      check_idle(3, "R8");
    end

    // R10: configuration changes during a run are ignored
    div_code = 5'd1; ratio_code = 4'd0; half_bits = 6'd16; mck_en = 1'b1; bypass = 1'b0;
    do_start();
    check_cycles(3, 48, 16, 1'b1, 1'b0, 0, 10, "R10 mck");
    div_code = 5'd17; ratio_code = 4'd8; half_bits = 6'd8; mck_en = 1'b0; bypass = 1'b1;
    check_cycles(3, 48, 16, 1'b1, 1'b0, 10, 200, "R10 mck held config");

    // R10: restart in mid-run realigns to k = 0 with fresh config
    div_code = 5'd2; ratio_code = 4'd0; half_bits = 6'd8; mck_en = 1'b1; bypass = 1'b0;
    do_start();
    check_cycles(4, 64, 8, 1'b1, 1'b0, 0, 140, "R10 mck restart");

    // R9: start and stop together during a run
    @(negedge clk) begin start_pulse = 1'b1; stop_pulse = 1'b1; end
    @(posedge clk); #1 begin start_pulse = 1'b0; stop_pulse = 1'b0; end
    check_idle(20, "R9 in run");

    // R9: start and stop together from the stopped state
    @(negedge clk) begin start_pulse = 1'b1; stop_pulse = 1'b1; end
    @(posedge clk); #1 begin start_pulse = 1'b0; stop_pulse = 1'b0; end
    check_idle(20, "R9 stopped");

    // R8: stop landing on the frame boundary (H = 48, k = 95 before the edge)
    div_code = 5'd1; ratio_code = 4'd0; half_bits = 6'd16; mck_en = 1'b1; bypass = 1'b0;
    do_start();
    check_cycles(3, 48, 16, 1'b1, 1'b0, 0, 95, "R2 mck");
    do_stop();
    check_idle(10, "R8 boundary");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule